// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Controller

This block runs the bus side of taking an interrupt in a processor with a 24-bit address bus. The core pulses a start strobe at an instruction boundary, after it has stacked its state. The block then picks between a periodic-timer request level and an external request level. It runs a CPU-space acknowledge cycle that carries the chosen level on the low address bits, and it captures that level into an interrupt-priority register. A pulse tells the core to clear the page-extension field of its condition register.

The cycle ends in one of three ways. A responder can return a vector number on the data bus together with a data acknowledge. An autovector request can make the vector from the priority. A bus error can select a fixed spurious vector. The vector number is doubled to form a word address, one read is made there, and the word returned becomes the new program counter. A one-cycle done pulse reports which of the three ways ended the cycle.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After synchronous reset, as_o, fc_o, addr_o, ip_o, path_o, pk_clr_o and done_o are all zero.
- R2: A start_i accepted while idle raises as_o at the next clock edge. At that edge fc_o becomes 3'b111 and addr_o becomes all ones in bits 23..4, the selected priority in bits 3..1 and 1 in bit 0. pk_clr_o is high for exactly that first cycle.
- R3: When both request levels are 0, start_i has no effect: as_o and pk_clr_o stay low.
- R4: The higher of tmr_prio_i and ext_prio_i is selected. On equal nonzero levels the timer wins. src_tmr_o is 1 while a timer-sourced cycle is in progress.
- R5: One cycle after the address is launched, ip_o holds addr_o[3:1]. It keeps that value for the rest of the cycle, even while the bus waits for a termination and even if start_i or the request levels change.
- R6: A data acknowledge (dack_i) alone ends the acknowledge cycle. The vector is data_i[7:0] and path_o is 1.
- R7: Autovector (avec_i), with or without dack_i, gives vector AUTO_BASE (0x18) plus ip_o and path_o 2.
- R8: Bus error (berr_i) takes precedence over the other terminations. It gives vector SPUR_VEC (0x0F) and path_o 2'd3.
- R9: After a termination, addr_o becomes the vector number times 2 and fc_o becomes 3'b101, with as_o still high. The next dack_i loads data_i into pc_o.
- R10: done_o is high for exactly one cycle, in the cycle after the fetch acknowledge. In that cycle as_o is low and vec_o, path_o and pc_o are valid. A start_i seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin servicing, from the core |
| tmr_prio_i | input | 3 | Periodic timer request level |
| ext_prio_i | input | 3 | External request level |
| dack_i | input | 1 | Data transfer acknowledge |
| avec_i | input | 1 | Autovector request |
| berr_i | input | 1 | Bus error |
| data_i | input | 16 | Read data bus |
| as_o | output | 1 | Bus cycle active |
| fc_o | output | 3 | Function code |
| addr_o | output | 24 | Address bus |
| pk_clr_o | output | 1 | Clear page-extension field pulse |
| ip_o | output | 3 | Interrupt priority register |
| src_tmr_o | output | 1 | Current cycle serves the timer request |
| vec_o | output | 8 | Chosen vector number |
| path_o | output | 2 | Completion path: 1 vector, 2 autovector, 3 spurious |
| pc_o | output | 16 | Word read from the vector address |
| done_o | output | 1 | Servicing finished pulse |

## Verification
The hardest case to reach is a cycle with two or three terminations asserted at once. The same case must also hold ip_o steady while the bus waits, while the core pokes start_i again with a new level. The bench sweeps every pair of timer and external levels. For each pair it picks a termination pattern in turn: acknowledge only, autovector, bus error, all three together, or autovector with acknowledge. It also varies how many idle wait cycles come before the termination. On one group of pairs it raises start_i with a different level during the wait, so that precedence and priority holding are both checked against levels computed in the bench.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int PRIO_W = 3;
  localparam int FC_W   = 3;
  localparam logic [FC_W-1:0] FC_CPU = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_WAIT,
    ST_FETCH,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    PATH_NONE = 2'd0,
    PATH_VEC  = 2'd1,
    PATH_AUTO = 2'd2,
    PATH_SPUR = 2'd3
  } term_path_t;
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_ack_pkg::*;
(
  input  logic [PRIO_W-1:0] tmr_prio,
  input  logic [PRIO_W-1:0] ext_prio,
  output logic [PRIO_W-1:0] sel_prio,
  output logic              sel_tmr
);
  // timer wins ties at the same level
  always_comb begin
    sel_tmr  = (tmr_prio >= ext_prio) && (tmr_prio != '0);
    sel_prio = sel_tmr ? tmr_prio : ext_prio;
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_ack_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 'h18,
  parameter int SPUR_VEC  = 'h0F
) (
  input  logic              berr,
  input  logic              avec,
  input  logic              dack,
  input  logic [PRIO_W-1:0] ip,
  input  logic [VEC_W-1:0]  bus_vec,
  output logic              term_hit,
  output term_path_t        path,
  output logic [VEC_W-1:0]  vec_num,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int PAD_W = ADDR_W - VEC_W - 1;

  always_comb begin
    term_hit = berr | avec | dack;
    if (berr) begin
      path    = PATH_SPUR;
      vec_num = VEC_W'(SPUR_VEC);
    end else if (avec) begin
      path    = PATH_AUTO;
      vec_num = VEC_W'(AUTO_BASE) + VEC_W'(ip);
    end else if (dack) begin
      path    = PATH_VEC;
      vec_num = bus_vec;
    end else begin
      path    = PATH_NONE;
      vec_num = '0;
    end
    vec_addr = {{PAD_W{1'b0}}, vec_num, 1'b0};
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8,
  parameter logic [FC_W-1:0] FETCH_FC = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PRIO_W-1:0] sel_prio,
  input  logic              sel_tmr,
  input  logic              dack,
  input  logic              term_hit,
  input  term_path_t        path_in,
  input  logic [VEC_W-1:0]  vec_in,
  input  logic [ADDR_W-1:0] vec_addr_in,
  input  logic [DATA_W-1:0] data,
  output seq_state_t        st_o,
  output logic [PRIO_W-1:0] ip_o,
  output logic              as_o,
  output logic [FC_W-1:0]   fc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pk_clr_o,
  output logic              src_tmr_o,
  output term_path_t        path_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              done_o
);
  localparam int ONES_W = ADDR_W - PRIO_W - 1;

  seq_state_t st;
  logic [ADDR_W-1:0] ack_addr;

  assign ack_addr = {{ONES_W{1'b1}}, sel_prio, 1'b1};
  assign st_o     = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ip_o      <= '0;
      as_o      <= 1'b0;
      fc_o      <= '0;
      addr_o    <= '0;
      pk_clr_o  <= 1'b0;
      src_tmr_o <= 1'b0;
      path_o    <= PATH_NONE;
      vec_o     <= '0;
      pc_o      <= '0;
      done_o    <= 1'b0;
    end else begin
      pk_clr_o <= 1'b0;
      done_o   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start && sel_prio != '0) begin
            st        <= ST_ACK;
            as_o      <= 1'b1;
            fc_o      <= FC_CPU;
            addr_o    <= ack_addr;
            pk_clr_o  <= 1'b1;
            src_tmr_o <= sel_tmr;
          end
        end
        ST_ACK: begin
          ip_o <= addr_o[PRIO_W:1];
          st   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (term_hit) begin
            vec_o  <= vec_in;
            path_o <= path_in;
            addr_o <= vec_addr_in;
            fc_o   <= FETCH_FC;
            st     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (dack) begin
            pc_o      <= data;
            as_o      <= 1'b0;
            fc_o      <= '0;
            addr_o    <= '0;
            src_tmr_o <= 1'b0;
            done_o    <= 1'b1;
            st        <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ACK_ENCODE: assert property (@(posedge clk) disable iff (rst)
    $rose(as_o) |-> (fc_o == FC_CPU && addr_o[0] && (&addr_o[ADDR_W-1:PRIO_W+1]))); // R2
  AST_PK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pk_clr_o |=> !pk_clr_o); // R2
  AST_PRIO_NONZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(as_o) |-> addr_o[PRIO_W:1] != '0); // R3
  AST_IP_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK) |=> (ip_o == $past(addr_o[PRIO_W:1]))); // R5
  AST_IP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT || st == ST_FETCH) |=> $stable(ip_o)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_DONE_BUS_OFF: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !as_o); // R10
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 'h18,
  parameter int SPUR_VEC  = 'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        tmr_prio_i,
  input  logic [2:0]        ext_prio_i,
  input  logic              dack_i,
  input  logic              avec_i,
  input  logic              berr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              as_o,
  output logic [2:0]        fc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pk_clr_o,
  output logic [2:0]        ip_o,
  output logic              src_tmr_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [1:0]        path_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              done_o
);
  logic [PRIO_W-1:0] sel_prio;
  logic              sel_tmr;
  logic              term_hit;
  term_path_t        path_c;
  term_path_t        path_q;
  logic [VEC_W-1:0]  vec_c;
  logic [ADDR_W-1:0] vec_addr_c;
  seq_state_t        st;

  irq_prio_sel u_sel (
    .tmr_prio (tmr_prio_i),
    .ext_prio (ext_prio_i),
    .sel_prio (sel_prio),
    .sel_tmr  (sel_tmr)
  );

  irq_vec_gen #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE), .SPUR_VEC(SPUR_VEC)
  ) u_vec (
    .berr     (berr_i),
    .avec     (avec_i),
    .dack     (dack_i),
    .ip       (ip_o),
    .bus_vec  (data_i[VEC_W-1:0]),
    .term_hit (term_hit),
    .path     (path_c),
    .vec_num  (vec_c),
    .vec_addr (vec_addr_c)
  );

  irq_ack_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start_i),
    .sel_prio    (sel_prio),
    .sel_tmr     (sel_tmr),
    .dack        (dack_i),
    .term_hit    (term_hit),
    .path_in     (path_c),
    .vec_in      (vec_c),
    .vec_addr_in (vec_addr_c),
    .data        (data_i),
    .st_o        (st),
    .ip_o        (ip_o),
    .as_o        (as_o),
    .fc_o        (fc_o),
    .addr_o      (addr_o),
    .pk_clr_o    (pk_clr_o),
    .src_tmr_o   (src_tmr_o),
    .path_o      (path_q),
    .vec_o       (vec_o),
    .pc_o        (pc_o),
    .done_o      (done_o)
  );

  assign path_o = path_q;

  AST_SPUR_WINS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && berr_i) |=> (path_o == 2'd3 && vec_o == VEC_W'(SPUR_VEC))); // R8
  AST_AUTO_OVER_DACK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && avec_i && !berr_i) |=> (path_o == 2'd2)); // R7
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && $past(st) == ST_WAIT && !term_hit) |-> $stable(addr_o)); // R9
endmodule

// File: tb/tb_irq_ack_ctrl.sv
module tb_irq_ack_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [2:0]  tmr_prio_i, ext_prio_i;
  logic        dack_i, avec_i, berr_i;
  logic [15:0] data_i;
  logic        as_o;
  logic [2:0]  fc_o;
  logic [23:0] addr_o;
  logic        pk_clr_o;
  logic [2:0]  ip_o;
  logic        src_tmr_o;
  logic [7:0]  vec_o;
  logic [1:0]  path_o;
  logic [15:0] pc_o;
  logic        done_o;

  int total = 0;
  int failed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_ack_ctrl dut (
    .clk(clk), .rst(rst), .start_i(start_i), .tmr_prio_i(tmr_prio_i),
    .ext_prio_i(ext_prio_i), .dack_i(dack_i), .avec_i(avec_i), .berr_i(berr_i),
    .data_i(data_i), .as_o(as_o), .fc_o(fc_o), .addr_o(addr_o),
    .pk_clr_o(pk_clr_o), .ip_o(ip_o), .src_tmr_o(src_tmr_o), .vec_o(vec_o),
    .path_o(path_o), .pc_o(pc_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 dack, 1 avec, 2 berr, 3 all three, 4 avec+dack
  task automatic txn(input int tp, input int ep, input int kind, input int hold, input bit poke);
    logic [2:0]  sel;
    logic        tsrc;
    logic [7:0]  dv, ev;
    logic [1:0]  ep_path;
    logic [15:0] pcv;
    tsrc = (tp >= ep);
    sel  = tsrc ? 3'(tp) : 3'(ep);
    dv   = 8'h40 + 8'(tp * 8 + ep);
    pcv  = 16'hA000 + 16'(tp * 8 + ep);
    case (kind)
      0:       begin ev = dv;                ep_path = 2'd1; end
      1, 4:    begin ev = 8'h18 + 8'(sel);   ep_path = 2'd2; end
      default: begin ev = 8'h0F;             ep_path = 2'd3; end
    endcase
    @(negedge clk);
    tmr_prio_i = 3'(tp); ext_prio_i = 3'(ep); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 as", as_o, 1);
    chk("R2 fc", fc_o, 3'b111);
    chk("R2 addr", addr_o, {20'hFFFFF, sel, 1'b1});
    chk("R2 pk", pk_clr_o, 1);
    @(negedge clk);
    chk("R5 ip", ip_o, sel);
    chk("R2 pk_low", pk_clr_o, 0);
    chk("R4 src", src_tmr_o, tsrc);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R5 ip_wait", ip_o, sel);
      chk("R5 as_wait", as_o, 1);
    end
    if (poke) begin
      start_i = 1'b1; tmr_prio_i = 3'd7; ext_prio_i = 3'd7;
    end
    data_i = {8'h00, dv};
    dack_i = (kind == 0 || kind == 3 || kind == 4);
    avec_i = (kind == 1 || kind == 3 || kind == 4);
    berr_i = (kind == 2 || kind == 3);
    @(negedge clk);
    dack_i = 0; avec_i = 0; berr_i = 0; start_i = 0;
    case (ep_path)
      2'd1: chk("R6 vec", vec_o, ev);
      2'd2: chk("R7 vec", vec_o, ev);
      default: chk("R8 vec", vec_o, ev);
    endcase
    chk("R8 path", path_o, ep_path);
    chk("R9 addr", addr_o, {15'd0, ev, 1'b0});
    chk("R9 fc", fc_o, 3'b101);
    chk("R9 as", as_o, 1);
    data_i = pcv; dack_i = 1'b1;
    @(negedge clk);
    dack_i = 1'b0;
    chk("R10 done", done_o, 1);
    chk("R9 pc", pc_o, pcv);
    chk("R10 as_low", as_o, 0);
    chk("R5 ip_kept", ip_o, sel);
    @(negedge clk);
    chk("R10 done_low", done_o, 0);
    chk("R10 idle", as_o, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    rst = 1; start_i = 0; tmr_prio_i = 0; ext_prio_i = 0;
    dack_i = 0; avec_i = 0; berr_i = 0; data_i = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 as", as_o, 0);
    chk("R1 fc", fc_o, 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 ip", ip_o, 0);
    chk("R1 path", path_o, 0);
    chk("R1 pk", pk_clr_o, 0);
    chk("R1 done", done_o, 0);
    // R3: level 0 on both sources
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R3 as", as_o, 0);
    chk("R3 pk", pk_clr_o, 0);
    @(negedge clk);
    chk("R3 as_later", as_o, 0);
    for (int tp = 0; tp < 8; tp++) begin
      for (int ep = 0; ep < 8; ep++) begin
        if (tp != 0 || ep != 0)
          txn(tp, ep, (tp * 8 + ep) % 5, ep % 3, (tp == 3));
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule